// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned words and a single carry input, and returns the sum word together with a carry output. It is purely combinational. The operand width is split into equal slices. Each slice resolves its own internal carries in one lookahead stage. Each slice also reports whether it creates a carry by itself (group generate) and whether it would pass an incoming carry through (group propagate).

A second lookahead stage turns those per-slice summaries into the carry entering every slice, plus the final carry output. No carry ripples from one slice to the next. Each carry at both levels is a sum of products over the generate and propagate terms and the primary carry input. It never depends on another computed carry.

The default build is 16 bits wide with four 4-bit slices. Width, slice size and the form of the per-bit propagate term are parameters. Illegal combinations are rejected at elaboration.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, with all values read as unsigned.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: A slice whose operands overflow without any incoming carry (for example 0xF + 0x1 in bits 7:4) delivers a carry into the next slice, even when no lower slice produces one.
- R4: A carry entering at bit 0 reaches every higher slice whose bits all propagate, with no ripple path between slices. For example 0x0FFF + 0x0000 + 1 gives 0x1000.
- R5: 0xFFFF + 0x0000 with carry input 1 gives sum 0x0000 and carry output 1.
- R6: 0xFFFF + 0xFFFF with carry input 1 gives sum 0xFFFF and carry output 1.
- R7: Zero operands with carry input 0 give sum 0 and carry output 0. With carry input 1 they give sum 1 and carry output 0.
- R8: The variant that forms the per-bit propagate as `a XOR b` (PROP_XOR=1) produces exactly the same `sum_o` and `cout_o` as the default variant that uses `a OR b`, for every input.
- R9: A 32-bit build with eight 4-bit slices meets R1 and R2. Its second lookahead stage then spans eight group signals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds three copies of the adder. The first is the default 16-bit, four-slice build with OR propagate. The second is the same width with XOR propagate, and it is driven with the same operands as the first so that the two variants are compared on every vector. The third is a 32-bit, eight-slice build, which exercises a second stage wider than the slice itself and carry chains that cross seven slice boundaries. Directed patterns target single-slice generate, full propagate chains and the all-ones corners.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // Largest slice width and largest slice count one lookahead stage accepts.
   localparam int unsigned CLA_MAX = 16;

   // Fully expanded lookahead: carry j+1 is the OR of every g[k] with all
   // the p above it up to j, plus the product of p[0..j] with the carry
   // input. No carry is built from another computed carry.
   function automatic logic [CLA_MAX:0] expand_carries(
      input logic [CLA_MAX-1:0] g,
      input logic [CLA_MAX-1:0] p,
      input logic               cin,
      input int unsigned        n
   );
      logic [CLA_MAX:0] c;
      logic             acc;
      logic             term;
      c    = '0;
      c[0] = cin;
      for (int j = 0; j < CLA_MAX; j++) begin
         if (j < int'(n)) begin
            acc = 1'b0;
            for (int k = 0; k <= j; k++) begin
               term = g[k];
               for (int m = k + 1; m <= j; m++) begin
                  term = term & p[m];
               end
               acc = acc | term;
            end
            term = cin;
            for (int m = 0; m <= j; m++) begin
               term = term & p[m];
            end
            c[j+1] = acc | term;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
   parameter int unsigned W         = 4,
   parameter bit          PROP_XOR  = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] gen_o,
   output logic [W-1:0] prop_o
);

   assign gen_o = a_i & b_i;

   generate
      if (PROP_XOR) begin : g_prop_xor
         assign prop_o = a_i ^ b_i;
      end else begin : g_prop_or
         assign prop_o = a_i | b_i;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         // R8
         pg_cover_chk: assert ((gen_o | prop_o) == (a_i | b_i));
      end
   end

endmodule

// File: rtl/cla_group.sv
module cla_group
   import cla_pkg::*;
#(
   parameter int unsigned GRP_W    = 4,
   parameter bit          PROP_XOR = 1'b0
) (
   input  logic [GRP_W-1:0] a_i,
   input  logic [GRP_W-1:0] b_i,
   input  logic             cin_i,
   output logic [GRP_W-1:0] sum_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);

   logic [GRP_W-1:0]   gen;
   logic [GRP_W-1:0]   prop;
   logic [CLA_MAX-1:0] gen_pad;
   logic [CLA_MAX-1:0] prop_pad;
   logic [CLA_MAX:0]   car_in;
   logic [CLA_MAX:0]   car_gen;
   logic [GRP_W-1:0]   bit_c;

   cla_bit_pg #(
      .W        (GRP_W),
      .PROP_XOR (PROP_XOR)
   ) pg_i (
      .a_i    (a_i),
      .b_i    (b_i),
      .gen_o  (gen),
      .prop_o (prop)
   );

   always_comb begin
      gen_pad              = '0;
      prop_pad             = '0;
      gen_pad[GRP_W-1:0]   = gen;
      prop_pad[GRP_W-1:0]  = prop;
      car_in               = expand_carries(gen_pad, prop_pad, cin_i, GRP_W);
      car_gen              = expand_carries(gen_pad, prop_pad, 1'b0, GRP_W);
      bit_c                = car_in[GRP_W-1:0];
      grp_gen_o            = car_gen[GRP_W];
      grp_prop_o           = &prop;
      sum_o                = a_i ^ b_i ^ bit_c;
   end

   logic [GRP_W:0] raw_sum;
   logic [GRP_W:0] full_sum;
   assign raw_sum  = {1'b0, a_i} + {1'b0, b_i};
   assign full_sum = raw_sum + {{GRP_W{1'b0}}, cin_i};

   always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
         // R3
         grp_gen_chk: assert (grp_gen_o == raw_sum[GRP_W]);
         // R4
         grp_prop_chk: assert (!(grp_prop_o && !grp_gen_o) || (raw_sum == {1'b0, {GRP_W{1'b1}}}));
         // R1
         grp_sum_chk: assert ({grp_gen_o | (grp_prop_o & cin_i), sum_o} == full_sum);
      end
   end

endmodule

// File: rtl/cla_level2.sv
module cla_level2
   import cla_pkg::*;
#(
   parameter int unsigned NG = 4
) (
   input  logic [NG-1:0] grp_gen_i,
   input  logic [NG-1:0] grp_prop_i,
   input  logic          cin_i,
   output logic [NG-1:0] grp_cin_o,
   output logic          cout_o
);

   logic [CLA_MAX-1:0] gen_pad;
   logic [CLA_MAX-1:0] prop_pad;
   logic [CLA_MAX:0]   car;

   always_comb begin
      gen_pad           = '0;
      prop_pad          = '0;
      gen_pad[NG-1:0]   = grp_gen_i;
      prop_pad[NG-1:0]  = grp_prop_i;
      car               = expand_carries(gen_pad, prop_pad, cin_i, NG);
      grp_cin_o         = car[NG-1:0];
      cout_o            = car[NG];
   end

   always_comb begin
      if (!$isunknown({grp_gen_i, grp_prop_i, cin_i})) begin
         // R4
         l2_first_chk: assert (grp_cin_o[0] == cin_i);
         // R3
         l2_all_gen_chk: assert (!(&grp_gen_i) || cout_o);
         // R2
         l2_kill_chk: assert (!(grp_gen_i == '0 && grp_prop_i == '0) || (cout_o == 1'b0));
      end
   end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
   import cla_pkg::*;
#(
   parameter int unsigned WIDTH    = 16,
   parameter int unsigned GRP_W    = 4,
   parameter bit          PROP_XOR = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int unsigned NUM_GRP = WIDTH / GRP_W;

   generate
      if (GRP_W < 2 || GRP_W > CLA_MAX) begin : g_bad_grp
         $error("lookahead_adder: GRP_W out of range");
      end
      if ((WIDTH % GRP_W) != 0) begin : g_bad_div
         $error("lookahead_adder: WIDTH must be a multiple of GRP_W");
      end
      if (NUM_GRP < 2 || NUM_GRP > CLA_MAX) begin : g_bad_cnt
         $error("lookahead_adder: slice count out of range");
      end
   endgenerate

   logic [NUM_GRP-1:0] grp_gen;
   logic [NUM_GRP-1:0] grp_prop;
   logic [NUM_GRP-1:0] grp_cin;

   for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_slice
      cla_group #(
         .GRP_W    (GRP_W),
         .PROP_XOR (PROP_XOR)
      ) grp_i (
         .a_i        (a_i[gi*GRP_W +: GRP_W]),
         .b_i        (b_i[gi*GRP_W +: GRP_W]),
         .cin_i      (grp_cin[gi]),
         .sum_o      (sum_o[gi*GRP_W +: GRP_W]),
         .grp_gen_o  (grp_gen[gi]),
         .grp_prop_o (grp_prop[gi])
      );
   end

   cla_level2 #(
      .NG (NUM_GRP)
   ) l2_i (
      .grp_gen_i  (grp_gen),
      .grp_prop_i (grp_prop),
      .cin_i      (cin_i),
      .grp_cin_o  (grp_cin),
      .cout_o     (cout_o)
   );

   logic [WIDTH:0]   ref_total;
   logic [WIDTH-1:0] ref_carry;
   assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
   assign ref_carry = ref_total[WIDTH-1:0] ^ a_i ^ b_i;

   always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
         // R1
         top_sum_chk: assert (sum_o == ref_total[WIDTH-1:0]);
         // R2
         top_cout_chk: assert (cout_o == ref_total[WIDTH]);
         for (int k = 0; k < int'(NUM_GRP); k++) begin
            // R4
            slice_cin_chk: assert (grp_cin[k] == ref_carry[k*int'(GRP_W)]);
         end
      end
   end

endmodule

// File: tb/lookahead_adder_tb_top.sv
module lookahead_adder_tb_top;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [15:0] a16 = '0, b16 = '0;
   logic        c16 = 1'b0;
   logic [15:0] s16, s16x;
   logic        co16, co16x;
   logic [31:0] a32 = '0, b32 = '0;
   logic        c32 = 1'b0;
   logic [31:0] s32;
   logic        co32;

   lookahead_adder #(.WIDTH(16), .GRP_W(4), .PROP_XOR(1'b0)) dut_i (
      .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));

   lookahead_adder #(.WIDTH(16), .GRP_W(4), .PROP_XOR(1'b1)) dut_xor_i (
      .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16x), .cout_o(co16x));

   lookahead_adder #(.WIDTH(32), .GRP_W(4), .PROP_XOR(1'b0)) dut_w32_i (
      .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));

   function automatic logic [16:0] exp16(input logic [15:0] a, input logic [15:0] b, input logic c);
      return 17'(a) + 17'(b) + 17'(c);
   endfunction

   function automatic logic [32:0] exp32(input logic [31:0] a, input logic [31:0] b, input logic c);
      return 33'(a) + 33'(b) + 33'(c);
   endfunction

   task automatic check(input string req, input logic [32:0] got, input logic [32:0] expv);
      checks++;
      if (got !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, expv);
      end
   endtask

   // Drive on the rising edge, compare at the falling edge.
   task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
      logic [16:0] e;
      @(posedge clk);
      a16 = a; b16 = b; c16 = c;
      @(negedge clk);
      e = exp16(a, b, c);
      check({req, " R1 sum"},  33'(s16),  33'(e[15:0]));
      check({req, " R2 cout"}, 33'(co16), 33'(e[16]));
      check({req, " R8 xor variant"}, 33'({co16x, s16x}), 33'({co16, s16}));
   endtask

   task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
      logic [32:0] e;
      @(posedge clk);
      a32 = a; b32 = b; c32 = c;
      @(negedge clk);
      e = exp32(a, b, c);
      check({req, " R9 wide"}, {co32, s32}, e);
   endtask

   initial begin
      for (int n = 0; n < 100000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      // R7: zero operands
      run16("R7 zero", 16'h0000, 16'h0000, 1'b0);
      check("R7 zero value", 33'({co16, s16}), 33'(0));
      run16("R7 zero+cin", 16'h0000, 16'h0000, 1'b1);
      check("R7 zero+cin value", 33'({co16, s16}), 33'(17'h00001));
      // R3: single-slice generate feeds the next slice
      run16("R3 gen slice1", 16'h00F0, 16'h0010, 1'b0);
      check("R3 gen slice1 value", 33'(s16), 33'(16'h0100));
      run16("R3 gen slice0", 16'h0008, 16'h0008, 1'b0);
      run16("R3 gen slice3", 16'h8000, 16'h8000, 1'b0);
      check("R3 gen top cout", 33'(co16), 33'(1));
      // R4: propagate chains across slices
      run16("R4 chain3", 16'h0FFF, 16'h0000, 1'b1);
      check("R4 chain3 value", 33'(s16), 33'(16'h1000));
      run16("R4 chain gen0", 16'h00FF, 16'h0F01, 1'b0);
      run16("R4 mixed prop", 16'h5A5A, 16'hA5A5, 1'b1);
      // R5, R6 corners
      run16("R5 ones+cin", 16'hFFFF, 16'h0000, 1'b1);
      check("R5 value", 33'({co16, s16}), 33'(17'h10000));
      run16("R6 ones+ones+cin", 16'hFFFF, 16'hFFFF, 1'b1);
      check("R6 value", 33'({co16, s16}), 33'(17'h1FFFF));
      run16("R6 ones+ones", 16'hFFFF, 16'hFFFF, 1'b0);
      // R1/R2/R8 random
      for (int i = 0; i < 3000; i++) begin
         run16("rand16", 16'($urandom), 16'($urandom), 1'($urandom));
      end
      // R9: wide build
      run32("R9 ones+cin", 32'hFFFF_FFFF, 32'h0, 1'b1);
      run32("R9 chain", 32'h0FFF_FFFF, 32'h0, 1'b1);
      run32("R9 ones+ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
      for (int i = 0; i < 2000; i++) begin
         run32("rand32", $urandom, $urandom, 1'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule